// File: doc/BRIEF.md
# Two-Cycle Bus Master with Region Chip Selects

This block is the processor-side master of a simple parallel memory bus with a 16-bit address and an 8-bit data path (bit 0 is the least significant data line, bit 7 the most significant). A client starts one single read or write with a valid/ready handshake. The controller then runs a fixed two-clock bus cycle. It drives the address from the first cycle. It asserts an active-low read or write strobe in the second cycle. It ends with a one-cycle completion pulse that carries the read byte.

The shared data lines are modelled as three signals: an outgoing byte, an incoming byte and an output enable. Read data is taken from the incoming byte on the falling clock edge inside the second cycle. Four address regions, chosen by the two top address bits, each have an active-low chip select. A parameter mask marks which regions hold a device. An address in an unmapped region selects nothing.

Top module: `bus2c_master`

## Requirements
- R1: After reset, req_ready is 1, rd_n and wr_n are 1, all cs_n bits are 1, bus_oe is 0 and done is 0.
- R2: A request is taken only on a rising edge where req_ready is 1. While a transfer is running, req_ready is 0, and changes on the request inputs do not alter bus_addr or the kind of strobe for that transfer.
- R3: In the first cycle after the accepting edge, bus_addr equals the requested address, and rd_n and wr_n are both 1.
- R4: In a read, rd_n is 0 in the second cycle only, and bus_oe stays 0 for the whole read. rd_n and wr_n are never both 0.
- R5: The byte delivered for a read is bus_din as sampled on the falling clock edge in the middle of the second cycle. It appears on rd_data in the done cycle and holds until the next read completes.
- R6: In a write, wr_n is 0 in the second cycle only, with bus_oe at 1 and bus_dout equal to the requested data.
- R7: After wr_n returns to 1, bus_oe stays 1 and bus_dout keeps the written byte for one more cycle. bus_oe then drops to 0.
- R8: During both cycles of a transfer, cs_n[i] is 0 exactly when address bits 15:14 equal i and region i is mapped. The default map enables regions 0, 1 and 3 and leaves region 2 unmapped, so an address there leaves cs_n at 4'hF. At most one cs_n bit is ever 0.
- R9: done is 1 for exactly one cycle, the cycle right after the second bus cycle. req_ready is 1 again in that same cycle.
- R10: Whenever no transfer is in its two bus cycles, rd_n and wr_n are 1 and cs_n is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Requested address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Outgoing data byte |
| bus_din | input | 8 | Incoming data byte |
| bus_oe | output | 1 | Master drives the data lines |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | 4 | Active-low chip selects, one per region |

## Verification
The bench drives writes and reads into every region, including the unmapped one. This shows whether the decoder selects the right device or none. It reads back bytes with only bit 7 or only bit 0 set, which exposes swapped or stuck data lines. The behavioural device puts its byte on bus_din only after the read strobe falls and shows a filler value otherwise, so a sample taken on a rising edge returns the wrong byte. The bench also keeps the request inputs busy with conflicting values during each transfer, which shows whether a request could be taken while the controller is busy.

// File: rtl/bus2c_pkg.sv
package bus2c_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ADDR   = 2'd1,
        PH_STROBE = 2'd2
    } phase_e;
endpackage

// File: rtl/bus2c_decode.sv
module bus2c_decode #(
    parameter int ADDR_W = 16,
    parameter int NUM_CS = 4,
    parameter logic [NUM_CS-1:0] CS_MAP = 4'b1011
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int SEL_W = $clog2(NUM_CS);

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1 -: SEL_W];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        if (CS_MAP[i]) begin : g_mapped
            assign cs_n[i] = !(active && (sel == SEL_W'(i)));
        end else begin : g_hole
            assign cs_n[i] = 1'b1;
        end
    end
endmodule

// File: rtl/bus2c_capture.sv
module bus2c_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (en) cap_d = din;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign q = cap_q;
endmodule

// File: rtl/bus2c_master.sv
module bus2c_master
    import bus2c_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int NUM_CS = 4,
    parameter logic [NUM_CS-1:0] CS_MAP = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic [NUM_CS-1:0] cs_n
);
    typedef struct packed {
        phase_e            ph;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rd_n;
        logic              wr_n;
        logic              oe;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        ph: PH_IDLE, wr: 1'b0, addr: '0, wdata: '0,
        rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, done: 1'b0, rdata: '0
    };

    regs_t             r_d, r_q;
    logic [DATA_W-1:0] cap_byte;
    logic              cap_en;

    assign cap_en = (r_q.ph == PH_STROBE) && !r_q.wr;

    bus2c_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_en),
        .din   (bus_din),
        .q     (cap_byte)
    );

    bus2c_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_MAP(CS_MAP)) u_dec (
        .active (r_q.ph != PH_IDLE),
        .addr   (r_q.addr),
        .cs_n   (cs_n)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                r_d.oe = 1'b0;
                if (req_valid) begin
                    r_d.ph    = PH_ADDR;
                    r_d.wr    = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                end
            end
            PH_ADDR: begin
                r_d.ph = PH_STROBE;
                if (r_q.wr) begin
                    r_d.wr_n = 1'b0;
                    r_d.oe   = 1'b1;
                end else begin
                    r_d.rd_n = 1'b0;
                end
            end
            PH_STROBE: begin
                r_d.ph   = PH_IDLE;
                r_d.rd_n = 1'b1;
                r_d.wr_n = 1'b1;
                r_d.done = 1'b1;
                if (!r_q.wr) r_d.rdata = cap_byte;
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.ph == PH_IDLE);
    assign done      = r_q.done;
    assign rd_data   = r_q.rdata;
    assign bus_addr  = r_q.addr;
    assign bus_dout  = r_q.wdata;
    assign bus_oe    = r_q.oe;
    assign rd_n      = r_q.rd_n;
    assign wr_n      = r_q.wr_n;

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE) |-> (rd_n && wr_n && (&cs_n)));
    a_r4_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));
    a_r4_read_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);
    a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (bus_oe && $stable(bus_dout)));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_STROBE) |-> $stable(bus_addr));
endmodule

// File: tb/bus2c_master_test.sv
module bus2c_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, bus_oe, rd_n, wr_n;
    logic [7:0]  rd_data, bus_dout;
    logic [7:0]  bus_din;
    logic [15:0] bus_addr;
    logic [3:0]  cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] mem [int];

    always #2.5 clk = ~clk;

    bus2c_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_oe(bus_oe), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
    );

    function automatic logic [7:0] dev_byte(logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [3:0] exp_cs(logic [15:0] a);
        logic [3:0] map = 4'b1011;
        if (map[a[15:14]]) return ~(4'b0001 << a[15:14]);
        return 4'hF;
    endfunction

    // behavioural device: drives only while strobed and selected
    always @(rd_n, cs_n, bus_addr) begin
        if (!rd_n && cs_n != 4'hF) bus_din = dev_byte(bus_addr);
        else                       bus_din = 8'hEE;
    end

    always @(negedge clk) begin
        if (!wr_n && cs_n != 4'hF) mem[int'(bus_addr)] = bus_dout;
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(logic wr, logic [15:0] a, logic [7:0] d);
        logic [7:0] expect_rd;
        logic       mapped;
        mapped = (exp_cs(a) != 4'hF);
        @(posedge clk); #2;
        check("R2 ready before request", {15'd0, req_ready}, 16'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        check("R3 address first cycle", bus_addr, a);
        check("R3 strobes high first cycle", {14'd0, rd_n, wr_n}, 16'd3);
        check("R8 select first cycle", {12'd0, cs_n}, {12'd0, exp_cs(a)});
        check("R2 busy not ready", {15'd0, req_ready}, 16'd0);
        #1;
        req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        @(posedge clk); #1;
        check("R2 address unchanged while busy", bus_addr, a);
        check("R8 select second cycle", {12'd0, cs_n}, {12'd0, exp_cs(a)});
        if (wr) begin
            check("R6 write strobe", {14'd0, rd_n, wr_n}, 16'd2);
            check("R6 drive enable", {15'd0, bus_oe}, 16'd1);
            check("R6 write byte", {8'd0, bus_dout}, {8'd0, d});
        end else begin
            check("R4 read strobe", {14'd0, rd_n, wr_n}, 16'd1);
            check("R4 drivers off", {15'd0, bus_oe}, 16'd0);
        end
        expect_rd = mapped ? dev_byte(a) : 8'hEE;
        #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 done pulse", {15'd0, done}, 16'd1);
        check("R9 ready with done", {15'd0, req_ready}, 16'd1);
        check("R10 strobes idle", {14'd0, rd_n, wr_n}, 16'd3);
        check("R10 selects idle", {12'd0, cs_n}, 16'h000F);
        if (wr) begin
            check("R7 hold enable", {15'd0, bus_oe}, 16'd1);
            check("R7 hold byte", {8'd0, bus_dout}, {8'd0, d});
        end else begin
            check("R5 read byte", {8'd0, rd_data}, {8'd0, expect_rd});
        end
        @(posedge clk); #1;
        check("R9 done single", {15'd0, done}, 16'd0);
        check("R7 release drive", {15'd0, bus_oe}, 16'd0);
        if (!wr) check("R5 read byte held", {8'd0, rd_data}, {8'd0, expect_rd});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready", {15'd0, req_ready}, 16'd1);
        check("R1 strobes", {14'd0, rd_n, wr_n}, 16'd3);
        check("R1 selects", {12'd0, cs_n}, 16'h000F);
        check("R1 oe and done", {14'd0, bus_oe, done}, 16'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 idle after reset", {12'd0, cs_n}, 16'h000F);

        xfer(1'b1, 16'h0012, 8'hA1);
        xfer(1'b0, 16'h0012, 8'h00);
        xfer(1'b1, 16'h4F00, 8'h80);   // D7 only
        xfer(1'b0, 16'h4F00, 8'h00);
        xfer(1'b1, 16'hFFFF, 8'h01);   // D0 only
        xfer(1'b0, 16'hFFFF, 8'h00);
        xfer(1'b0, 16'hC123, 8'h00);   // unwritten region 3
        xfer(1'b0, 16'h8000, 8'h00);   // unmapped region 2 read
        xfer(1'b1, 16'h8001, 8'h77);   // unmapped region 2 write
        xfer(1'b0, 16'h4001, 8'h00);
        check("R8 unmapped write stored nothing", {15'd0, mem.exists(int'(16'h8001))}, 16'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule